// File: doc/BRIEF.md
# Four-Line Activation and Loopback Router

The block serves four line channels. Each line owns an 8-bit control word, written and read through a small register port. The control word decides whether the line is activated, which of four loopback paths is closed, whether the line may raise an interrupt, and whether each direction of the D channel is passed or replaced by idle. Every line has two sources: a received line frame and a digital transmit frame. It has two sinks: a line transmit frame and a digital receive frame. Each frame carries a B1 byte, a B2 byte and a 2-bit D field.

A two-state machine for each line follows its activation bit. In `LN_OFF` the line is powered down. It sends an all-zero frame toward the line, its valid output is low, and no loopback bit has any effect. The transition `GO_UP` (activation bit seen high) enters `LN_ON`, and the transition `GO_DOWN` (activation bit seen low) returns to `LN_OFF`. Each transition takes one clock edge after the register changes. The control word is kept in both states. A device-level power-up indication is raised while any line has its activation bit set.

Top module: `qline_router`

## Requirements
- R1: After reset every control word reads 0, every line is in `LN_OFF`, every line transmit frame is 0, and every valid output and the power-up output are low.
- R2: A write stores `reg_wdata_i` into the word of line `reg_addr_i` at the clock edge. `reg_rdata_o` shows the addressed word combinationally. Words are kept and stay readable and writable while a line is deactivated, and a write changes only the addressed word.
- R3: Control bit 7 = 1 activates the line. The line enters `LN_ON` and raises its valid output one edge after the word holds the bit. Clearing bit 7 returns the line to `LN_OFF`, with an all-zero line transmit frame and valid low.
- R4: `pwr_up_o` is high exactly when bit 7 is set in at least one control word.
- R5: Frame layout is B1 in bits [17:10], B2 in [9:2] and D in [1:0]. Bit 6 (digital loopback) on an active line sends the digital transmit frame to the digital receive output unchanged. The line transmit output still carries the digital transmit frame.
- R6: Bit 5 (full line loopback) on an active line sends the received line frame to the line transmit output unchanged. The digital receive output still carries the received line frame.
- R7: Bit 4 on an active line returns only B1 of the received line frame to the line. B2 and D toward the line come from the digital transmit frame.
- R8: Bit 3 on an active line returns only B2 of the received line frame to the line. B1 and D come from the digital transmit frame.
- R9: When bit 5 is set with bit 4 or bit 3, the full line loopback wins. Digital and line loopback may be active together.
- R10: Bits 6..3 have no effect on a deactivated line. The digital receive output then carries the received line frame.
- R11: Bit 1 = 1 replaces the D field from the digital side toward the line with idle 2'b11.
- R12: Bit 0 = 1 replaces the D field from the line toward the digital side with idle 2'b11.
- R13: `irq_o` is high when some line has bit 2 set and its `irq_req_i` bit high. Requests from lines with bit 2 clear are masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Line index for read and write |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Control word of the addressed line |
| ln_rx_i | input | 72 | Received line frames, 18 bits per line, line n at [18n +: 18] |
| dg_tx_i | input | 72 | Digital transmit frames, same packing |
| ln_tx_o | output | 72 | Line transmit frames |
| dg_rx_o | output | 72 | Digital receive frames |
| ln_vld_o | output | 4 | Line n active |
| irq_req_i | input | 4 | Per-line interrupt request |
| irq_o | output | 1 | Gated interrupt |
| pwr_up_o | output | 1 | Device power-up indication |

## Verification
The data-path assertions treat the frame inputs as free to change on any cycle. They compare the outputs against the inputs only in the same cycle, so they rely on nothing about the input timing. The register-hold assertion assumes every word changes only through `reg_we_i`. The bench drives the strobe, the address and the frame inputs only on falling edges, and it raises the strobe for exactly one cycle per write. After each write it waits one further edge for the state machine before it samples the outputs.

// File: rtl/qline_pkg.sv
package qline_pkg;
    localparam int BW = 8;
    localparam int DW = 2;
    localparam int FW = 2 * BW + DW;
    localparam int CW = 8;

    localparam int C_ACT   = 7;
    localparam int C_DLOOP = 6;
    localparam int C_LFULL = 5;
    localparam int C_LB1   = 4;
    localparam int C_LB2   = 3;
    localparam int C_IRQEN = 2;
    localparam int C_DTXOFF = 1;
    localparam int C_DRXOFF = 0;

    localparam logic [DW-1:0] D_IDLE = '1;

    typedef struct packed {
        logic [BW-1:0] b1;
        logic [BW-1:0] b2;
        logic [DW-1:0] d;
    } frame_t;

    typedef enum logic {LN_OFF = 1'b0, LN_ON = 1'b1} ln_state_e;
endpackage

// File: rtl/qline_regs.sv
module qline_regs
    import qline_pkg::*;
#(
    parameter int NL = 4,
    localparam int AW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [CW-1:0]   wdata_i,
    output logic [CW-1:0]   rdata_o,
    output logic [NL*CW-1:0] ctrl_o
);
    logic [CW-1:0] ctrl_q [NL];

    for (genvar n = 0; n < NL; n++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctrl_q[n] <= '0;
            else if (we_i && (int'(addr_i) == n))
                ctrl_q[n] <= wdata_i;
        end
        assign ctrl_o[n*CW +: CW] = ctrl_q[n];

        AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(we_i && (int'(addr_i) == n)) |=> $stable(ctrl_o[n*CW +: CW])); // R2
    end

    always_comb begin
        rdata_o = '0;
        for (int n = 0; n < NL; n++)
            if (int'(addr_i) == n) rdata_o = ctrl_q[n];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (rdata_o == $past(wdata_i)) || (addr_i != $past(addr_i))); // R2
endmodule

// File: rtl/qline_fsm.sv
module qline_fsm
    import qline_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_req_i,
    output logic active_o
);
    ln_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LN_OFF: if (act_req_i)  state_d = LN_ON;   // GO_UP
            LN_ON:  if (!act_req_i) state_d = LN_OFF;  // GO_DOWN
            default: state_d = LN_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LN_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            LN_ON:   active_o = 1'b1;
            default: active_o = 1'b0;
        endcase
    end

    AST_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        act_req_i |=> active_o); // R3
    AST_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !act_req_i |=> !active_o); // R3
endmodule

// File: rtl/qline_path.sv
module qline_path
    import qline_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active_i,
    input  logic [CW-1:0] ctrl_i,
    input  frame_t        ln_rx_i,
    input  frame_t        dg_tx_i,
    output frame_t        ln_tx_o,
    output frame_t        dg_rx_o
);
    frame_t from_line, from_dig, mix;

    always_comb begin
        from_line   = ln_rx_i;
        from_line.d = ctrl_i[C_DRXOFF] ? D_IDLE : ln_rx_i.d;
        from_dig    = dg_tx_i;
        from_dig.d  = ctrl_i[C_DTXOFF] ? D_IDLE : dg_tx_i.d;

        mix    = from_dig;
        if (ctrl_i[C_LB1]) mix.b1 = ln_rx_i.b1;
        if (ctrl_i[C_LB2]) mix.b2 = ln_rx_i.b2;

        if (!active_i)
            ln_tx_o = '0;
        else if (ctrl_i[C_LFULL])
            ln_tx_o = ln_rx_i;
        else
            ln_tx_o = mix;

        if (active_i && ctrl_i[C_DLOOP])
            dg_rx_o = dg_tx_i;
        else
            dg_rx_o = from_line;
    end

    AST_IDLE_WHEN_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> (ln_tx_o == '0)); // R3
    AST_FULL_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && ctrl_i[C_LFULL]) |-> (ln_tx_o == ln_rx_i)); // R9
    AST_DIG_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && ctrl_i[C_DLOOP]) |-> (dg_rx_o == dg_tx_i)); // R5
    AST_DOWN_NO_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |-> (dg_rx_o.b1 == ln_rx_i.b1 && dg_rx_o.b2 == ln_rx_i.b2)); // R10
endmodule

// File: rtl/qline_router.sv
module qline_router
    import qline_pkg::*;
#(
    parameter int NL = 4,
    localparam int AW = (NL > 1) ? $clog2(NL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we_i,
    input  logic [AW-1:0]    reg_addr_i,
    input  logic [CW-1:0]    reg_wdata_i,
    output logic [CW-1:0]    reg_rdata_o,
    input  logic [NL*FW-1:0] ln_rx_i,
    input  logic [NL*FW-1:0] dg_tx_i,
    output logic [NL*FW-1:0] ln_tx_o,
    output logic [NL*FW-1:0] dg_rx_o,
    output logic [NL-1:0]    ln_vld_o,
    input  logic [NL-1:0]    irq_req_i,
    output logic             irq_o,
    output logic             pwr_up_o
);
    logic [NL*CW-1:0] ctrl;
    logic [NL-1:0]    act_bits, irq_en;

    qline_regs #(.NL(NL)) u_regs (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .ctrl_o(ctrl)
    );

    for (genvar n = 0; n < NL; n++) begin : g_line
        assign act_bits[n] = ctrl[n*CW + C_ACT];
        assign irq_en[n]   = ctrl[n*CW + C_IRQEN];

        qline_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .act_req_i(act_bits[n]), .active_o(ln_vld_o[n])
        );

        qline_path u_path (
            .clk(clk), .rst_n(rst_n), .active_i(ln_vld_o[n]),
            .ctrl_i(ctrl[n*CW +: CW]),
            .ln_rx_i(ln_rx_i[n*FW +: FW]), .dg_tx_i(dg_tx_i[n*FW +: FW]),
            .ln_tx_o(ln_tx_o[n*FW +: FW]), .dg_rx_o(dg_rx_o[n*FW +: FW])
        );
    end

    assign pwr_up_o = |act_bits;
    assign irq_o    = |(irq_req_i & irq_en);

    AST_PWR_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we_i && reg_wdata_i[C_ACT]) |=> pwr_up_o); // R4
    AST_PWR_COVERS_LINES: assert property (@(posedge clk) disable iff (!rst_n)
        (ln_vld_o != '0) && $stable(pwr_up_o) |-> pwr_up_o || $past(pwr_up_o)); // R4
    AST_IRQ_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_req_i != '0)); // R13
endmodule

// File: tb/test_qline_router.sv
module test_qline_router;
    import qline_pkg::*;
    localparam int NL = 4;

    logic clk = 0, rst_n = 0;
    logic reg_we = 0;
    logic [1:0] reg_addr = 0;
    logic [7:0] reg_wdata = 0, reg_rdata;
    logic [NL*FW-1:0] ln_rx = 0, dg_tx = 0, ln_tx, dg_rx;
    logic [NL-1:0] vld, irq_req = 0;
    logic irq, pwr;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    qline_router #(.NL(NL)) i_qline_router (
        .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
        .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .ln_rx_i(ln_rx), .dg_tx_i(dg_tx), .ln_tx_o(ln_tx), .dg_rx_o(dg_rx),
        .ln_vld_o(vld), .irq_req_i(irq_req), .irq_o(irq), .pwr_up_o(pwr)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(int ln, logic [7:0] v);
        @(negedge clk);
        reg_we = 1; reg_addr = 2'(ln); reg_wdata = v;
        @(negedge clk);
        reg_we = 0;
        @(negedge clk);
    endtask

    function automatic frame_t fr(logic [7:0] b1, logic [7:0] b2, logic [1:0] d);
        frame_t f; f.b1 = b1; f.b2 = b2; f.d = d; return f;
    endfunction

    task automatic set_frames(int ln, frame_t rx, frame_t tx);
        ln_rx[ln*FW +: FW] = rx; dg_tx[ln*FW +: FW] = tx; #1;
    endtask

    function automatic logic [31:0] ltx(int ln); return 32'(ln_tx[ln*FW +: FW]); endfunction
    function automatic logic [31:0] drx(int ln); return 32'(dg_rx[ln*FW +: FW]); endfunction

    task automatic t_reset();
        for (int n = 0; n < NL; n++) begin
            reg_addr = 2'(n); #1;
            chk("R1 ctrl", 32'(reg_rdata), 0);
            chk("R1 ltx", ltx(n), 0);
        end
        chk("R1 vld", 32'(vld), 0);
        chk("R1 pwr", 32'(pwr), 0);
    endtask

    task automatic t_retain();
        wr(2, 8'h5A);
        reg_addr = 2; #1; chk("R2 readback", 32'(reg_rdata), 32'h5A);
        reg_addr = 1; #1; chk("R2 neighbour", 32'(reg_rdata), 0);
        chk("R2 still down", 32'(vld), 0);
        wr(2, 8'h00);
    endtask

    task automatic t_activate();
        frame_t rx = fr(8'h11, 8'h22, 2'b01), tx = fr(8'hA1, 8'hB2, 2'b10);
        @(negedge clk);
        reg_we = 1; reg_addr = 0; reg_wdata = 8'h80;
        @(negedge clk);
        reg_we = 0;
        chk("R4 pwr", 32'(pwr), 1);
        chk("R3 not yet", 32'(vld[0]), 0);
        @(negedge clk);
        chk("R3 up", 32'(vld[0]), 1);
        set_frames(0, rx, tx);
        chk("R3 ltx", ltx(0), 32'(tx));
        chk("R3 drx", drx(0), 32'(rx));
        wr(0, 8'h00);
        chk("R3 down vld", 32'(vld[0]), 0);
        chk("R3 down idle", ltx(0), 0);
        chk("R4 pwr off", 32'(pwr), 0);
    endtask

    task automatic t_loops();
        frame_t rx = fr(8'h3C, 8'hC3, 2'b00), tx = fr(8'h96, 8'h69, 2'b01);
        set_frames(1, rx, tx);
        wr(1, 8'hC0);
        chk("R5 drx", drx(1), 32'(tx));
        chk("R5 ltx", ltx(1), 32'(tx));
        wr(1, 8'hA0);
        chk("R6 ltx", ltx(1), 32'(rx));
        chk("R6 drx", drx(1), 32'(rx));
        wr(1, 8'h90);
        chk("R7 ltx", ltx(1), 32'(fr(8'h3C, 8'h69, 2'b01)));
        wr(1, 8'h88);
        chk("R8 ltx", ltx(1), 32'(fr(8'h96, 8'hC3, 2'b01)));
        wr(1, 8'hB8);
        chk("R9 prio", ltx(1), 32'(rx));
        wr(1, 8'hE0);
        chk("R9 both ltx", ltx(1), 32'(rx));
        chk("R9 both drx", drx(1), 32'(tx));
        wr(1, 8'h78);
        chk("R10 ltx", ltx(1), 0);
        chk("R10 drx", drx(1), 32'(rx));
        wr(1, 8'h00);
    endtask

    task automatic t_dgate();
        frame_t rx = fr(8'h01, 8'h02, 2'b00), tx = fr(8'h03, 8'h04, 2'b00);
        set_frames(3, rx, tx);
        wr(3, 8'h82);
        chk("R11 ltx", ltx(3), 32'(fr(8'h03, 8'h04, 2'b11)));
        chk("R11 drx", drx(3), 32'(rx));
        wr(3, 8'h81);
        chk("R12 drx", drx(3), 32'(fr(8'h01, 8'h02, 2'b11)));
        chk("R12 ltx", ltx(3), 32'(tx));
        wr(3, 8'h00);
    endtask

    task automatic t_irq();
        irq_req = 4'b0100; #1;
        chk("R13 masked", 32'(irq), 0);
        wr(2, 8'h04);
        chk("R13 enabled", 32'(irq), 1);
        irq_req = 4'b1011; #1;
        chk("R13 other lines", 32'(irq), 0);
        irq_req = 0;
        wr(2, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_retain();
        t_activate();
        t_loops();
        t_dgate();
        t_irq();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule